// File: doc/BRIEF.md
# Circular Buffer Address Adder

This block is the address arithmetic step of a DSP data path. Each operation takes a 32-bit base address and an offset. The offset comes from a register or from a small unsigned constant. The block scales the offset by the element size, then adds it to the base or subtracts it from the base. The new address appears on the output one clock later, ready to be written back to the base register.

A per-register mode field picks linear or circular arithmetic. In linear mode the sum spans the full address width. In circular mode a block-size field gives a bit position N, and the buffer is 2^(N+1) bytes. The carry or borrow out of bit N is suppressed, and every bit above N is copied from the base. The address therefore wraps inside an aligned power-of-two window, with no compare or correction step. The block size is always a byte count and does not depend on the element size.

Top module: `circ_addr_top`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `addrOut` is zero.
- R2: The offset is shifted left before the add or subtract by an amount set by `sizeSel`:
  - `00` (byte) shifts by 0.
  - `01` (halfword) shifts by 1.
  - `10` (word) shifts by 2.
  - `11` is treated as byte.
- R3: With `offSel` = 0 the offset is `offReg`. With `offSel` = 1 the offset is `cstIn`, zero-extended.
- R4: With `modeSel` `00` or `11` (linear), the result is base plus or minus the scaled offset, modulo 2^32.
- R5: With `modeSel` `01`, N is `bk0`. With `modeSel` `10`, N is `bk1`. In both cases, result bits N+1 through 31 equal the corresponding base bits.
- R6: In circular mode, result bits 0 through N equal (base ± scaled offset) modulo 2^(N+1). An offset of one block or more is therefore reduced modulo the block size. For example, with N = 4:
  - base 100h plus 13h halfwords gives 106h.
  - base 100h plus 9 words gives 104h.
- R7: In circular mode with N = 31, the result equals the linear result.
- R8: The result is taken at the rising edge where `load` is high and appears on `addrOut` just after that edge. While `load` is low, `addrOut` holds its value.
- R9: With `subOp` = 0 the block adds the scaled offset. With `subOp` = 1 it subtracts the scaled offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Compute and register a new address this cycle |
| subOp | input | 1 | 1 = subtract offset, 0 = add |
| offSel | input | 1 | 1 = constant offset, 0 = register offset |
| sizeSel | input | 2 | Element size: 00 byte, 01 half, 10 word, 11 byte |
| modeSel | input | 2 | 00 linear, 01 circular with bk0, 10 circular with bk1, 11 linear |
| bk0 | input | 5 | Block-size field 0 (N) |
| bk1 | input | 5 | Block-size field 1 (N) |
| baseIn | input | 32 | Base address |
| offReg | input | 32 | Register offset |
| cstIn | input | 5 | Constant offset |
| addrOut | output | 32 | Registered new address |

## Verification
A wrong carry-kill position shows up one cycle after the load edge. It appears either as a changed bit above N, or as a missing carry into a low bit, whenever the offset crosses the block boundary. A wrong scale or operand select corrupts the low address bits within that same single cycle. A result register that updates without `load` shows up as a changed `addrOut` on the cycle after the idle edge. The sweep covers every mode, element size, direction and offset source, across several values of N including 0 and 31, so each of these faults becomes visible at the ports within one clock.

// File: rtl/circ_addr_pkg.sv
package circ_addr_pkg;
  parameter int ADDR_W = 32;
  localparam int NW = $clog2(ADDR_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } sizeE;

  typedef enum logic [1:0] {
    MD_LIN  = 2'b00,
    MD_BK0  = 2'b01,
    MD_BK1  = 2'b10,
    MD_RSVD = 2'b11
  } modeE;

  typedef struct packed {
    logic          load;
    logic          sub;
    logic          selCst;
    logic [1:0]    shAmt;
    logic          circ;
    logic [NW-1:0] nBit;
  } strobeT;
endpackage

// File: rtl/circ_addr_ctrl.sv
module circ_addr_ctrl
  import circ_addr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic          subOp,
  input  logic          offSel,
  input  logic [1:0]    sizeSel,
  input  logic [1:0]    modeSel,
  input  logic [NW-1:0] bk0,
  input  logic [NW-1:0] bk1,
  output strobeT        strb
);
  always_comb begin
    strb.load   = load;
    strb.sub    = subOp;
    strb.selCst = offSel;
    unique case (sizeE'(sizeSel))
      SZ_HALF: strb.shAmt = 2'd1;
      SZ_WORD: strb.shAmt = 2'd2;
      default: strb.shAmt = 2'd0;
    endcase
    unique case (modeE'(modeSel))
      MD_BK0: begin strb.circ = 1'b1; strb.nBit = bk0; end
      MD_BK1: begin strb.circ = 1'b1; strb.nBit = bk1; end
      default: begin strb.circ = 1'b0; strb.nBit = '0; end
    endcase
  end

  // R2
  shamt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shAmt != 2'd3);
endmodule

// File: rtl/circ_addr_dp.sv
module circ_addr_dp
  import circ_addr_pkg::*;
#(
  parameter int CST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] offReg,
  input  logic [CST_W-1:0]  cstIn,
  output logic [ADDR_W-1:0] addrOut
);
  logic [ADDR_W-1:0] opnd, scaled, bOp, keepHi, nxt;

  always_comb begin
    opnd   = strb.selCst ? {{(ADDR_W-CST_W){1'b0}}, cstIn} : offReg;
    scaled = opnd << strb.shAmt;
    bOp    = strb.sub ? ~scaled : scaled;
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
    assign keepHi[i] = strb.circ && (i > int'(strb.nBit));
  end

  always_comb begin
    logic cy;
    logic s;
    cy  = strb.sub;
    nxt = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      s      = baseIn[i] ^ bOp[i] ^ cy;
      nxt[i] = keepHi[i] ? baseIn[i] : s;
      cy     = ((baseIn[i] & bOp[i]) | (cy & (baseIn[i] ^ bOp[i])))
               & ~(strb.circ && (i == int'(strb.nBit)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          addrOut <= '0;
    else if (strb.load) addrOut <= nxt;
  end

  // R5
  hi_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~keepHi) & ((~keepHi) + 1'b1)) == '0);
  // R5
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> ((addrOut ^ $past(baseIn)) & $past(keepHi)) == '0);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(addrOut));
  // R1
  rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> addrOut == '0);
endmodule

// File: rtl/circ_addr_top.sv
module circ_addr_top
  import circ_addr_pkg::*;
#(
  parameter int CST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              subOp,
  input  logic              offSel,
  input  logic [1:0]        sizeSel,
  input  logic [1:0]        modeSel,
  input  logic [NW-1:0]     bk0,
  input  logic [NW-1:0]     bk1,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [ADDR_W-1:0] offReg,
  input  logic [CST_W-1:0]  cstIn,
  output logic [ADDR_W-1:0] addrOut
);
  strobeT strb;

  circ_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .load(load), .subOp(subOp), .offSel(offSel),
    .sizeSel(sizeSel), .modeSel(modeSel), .bk0(bk0), .bk1(bk1), .strb(strb)
  );

  circ_addr_dp #(.CST_W(CST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .baseIn(baseIn),
    .offReg(offReg), .cstIn(cstIn), .addrOut(addrOut)
  );
endmodule

// File: tb/sim_circ_addr_top.sv
`timescale 1ns/1ps
module sim_circ_addr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        load = 1'b0, subOp = 1'b0, offSel = 1'b0;
  logic [1:0]  sizeSel = '0, modeSel = '0;
  logic [4:0]  bk0 = '0, bk1 = '0, cstIn = '0;
  logic [31:0] baseIn = '0, offReg = '0;
  logic [31:0] addrOut;
  int          nRun = 0, nFail = 0;
  logic [31:0] rng = 32'h1234_5677;

  always #5 clk = ~clk;

  circ_addr_top u0 (
    .clk(clk), .rstN(rstN), .load(load), .subOp(subOp), .offSel(offSel),
    .sizeSel(sizeSel), .modeSel(modeSel), .bk0(bk0), .bk1(bk1),
    .baseIn(baseIn), .offReg(offReg), .cstIn(cstIn), .addrOut(addrOut)
  );

  function automatic logic [31:0] nextRnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] refModel(
    input logic [31:0] b, input logic [31:0] o, input logic [4:0] c,
    input logic sel, input logic [1:0] sz, input logic sub,
    input logic [1:0] md, input logic [4:0] k0, input logic [4:0] k1);
    logic [31:0] op, sc, full, mask;
    logic [4:0]  n;
    op = sel ? {27'd0, c} : o;
    sc = (sz == 2'b01) ? op * 2 : (sz == 2'b10) ? op * 4 : op;
    full = sub ? b - sc : b + sc;
    if (md == 2'b01 || md == 2'b10) begin
      n = (md == 2'b01) ? k0 : k1;
      mask = (n == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (n + 1)) - 1);
      return (b & ~mask) | (full & mask);
    end
    return full;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input string req, input logic [31:0] b, input logic [31:0] o,
                      input logic [4:0] c, input logic sel, input logic [1:0] sz,
                      input logic sub, input logic [1:0] md,
                      input logic [4:0] k0, input logic [4:0] k1);
    baseIn = b; offReg = o; cstIn = c; offSel = sel; sizeSel = sz;
    subOp = sub; modeSel = md; bk0 = k0; bk1 = k1; load = 1'b1;
    @(posedge clk); @(negedge clk);
    load = 1'b0;
    check(req, addrOut, refModel(b, o, c, sel, sz, sub, md, k0, k1));
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [4:0] ks [7];
    logic [31:0] held;
    ks = '{5'd0, 5'd3, 5'd4, 5'd7, 5'd15, 5'd30, 5'd31};
    repeat (3) @(negedge clk);
    check("R1 in reset", addrOut, 32'h0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", addrOut, 32'h0);

    // R6 worked examples, N = 4 through bk0
    doOp("R6 half 13h", 32'h100, 32'h13, 5'd0, 1'b0, 2'b01, 1'b0, 2'b01, 5'd4, 5'd0);
    check("R6 half 13h value", addrOut, 32'h106);
    doOp("R6 cst 9 words", 32'h100, 32'h0, 5'd9, 1'b1, 2'b10, 1'b0, 2'b01, 5'd4, 5'd0);
    check("R6 cst 9 words value", addrOut, 32'h104);
    // R5 bk1 select, R9 subtract borrow wraps
    doOp("R5 R9 bk1 sub", 32'hABCD_0102, 32'h4, 5'd0, 1'b0, 2'b00, 1'b1, 2'b10, 5'd0, 5'd3);
    check("R9 sub wrap value", addrOut, 32'hABCD_010E);
    // R4 linear overflow, R7 N=31
    doOp("R4 linear wrap", 32'hFFFF_FFFC, 32'h2, 5'd0, 1'b0, 2'b10, 1'b0, 2'b00, 5'd0, 5'd0);
    doOp("R7 N31", 32'hFFFF_FFFC, 32'h2, 5'd0, 1'b0, 2'b10, 1'b0, 2'b01, 5'd31, 5'd0);
    check("R7 N31 value", addrOut, 32'h4);

    // R8 hold while load low
    held = addrOut;
    baseIn = 32'h5555_5555; offReg = 32'h77; modeSel = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 hold", addrOut, held);

    // Sweep: R2 R3 R4 R5 R6 R7 R9
    for (int md = 0; md < 4; md++)
      for (int sz = 0; sz < 4; sz++)
        for (int sb = 0; sb < 2; sb++)
          for (int sl = 0; sl < 2; sl++)
            for (int ki = 0; ki < 7; ki++)
              for (int r = 0; r < 6; r++) begin
                logic [31:0] b, o;
                rng = nextRnd(rng); b = rng;
                rng = nextRnd(rng); o = (r < 3) ? (rng & 32'h3F) : rng;
                doOp("R2 R3 R4 R5 R6 R9 sweep", b, o, rng[12:8], sl[0], sz[1:0],
                     sb[0], md[1:0], ks[ki], ks[6-ki]);
              end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule